// File: doc/BRIEF.md
# Graphic LCD Command Interpreter

This block is the panel-side receiver of a parallel graphic LCD bus. Each host access arrives as a one-cycle strobe together with a register-select line, a read/write line and an 8-bit data byte. With register select high the access reaches the display data RAM. That RAM is 8 pages of 128 byte-wide columns. With register select low, a write is a command byte and a read returns a status byte. A column pointer is shared by RAM reads and RAM writes and advances after each of them.

Three command forms are decoded: display enable, start line, and a two-byte reference-voltage setting in which an arming byte precedes the parameter. The results are held on output ports so that the drive and bias logic can use them. The page address, the column address and the segment-direction flag are loaded through a separate side-band load port. A timer makes the block busy after reset and after every accepted write. While it is busy, every access except a status read is dropped.

Top module: `lcd_cmd_interp`

## Requirements
- R1: On release of reset the display is off, the start line, reference voltage, page, column and segment-direction flag are 0, and the block stays busy with its init flag set for 4 clock cycles.
- R2: A write with rs_i=1 stores wdata_i at the current page and column and advances the column by one. Like every accepted command, it holds busy_o high for the following 2 cycles.
- R3: A read with rs_i=1 returns the byte at the current page and column on rdata_o, with rvalid_o high, in the cycle after the strobe. The column then advances by one.
- R4: On a RAM access the column wraps from 127 to 0, and the page is left unchanged.
- R5: A read with rs_i=0 returns the status byte: bit 7 busy, bit 6 segment-direction flag, bit 5 display enable, bit 4 init-in-progress, bits 3..0 zero. The busy and init bits are the values seen at the strobe.
- R6: The command byte 1010111b sets disp_on_o to b.
- R7: A command byte of the form 01xxxxxx loads its low six bits into start_line_o.
- R8: The command byte 0x81 arms reference-voltage mode. The next command byte of any value becomes the parameter: its low six bits go to vref_o, its top two bits are ignored, and the mode is disarmed.
- R9: While busy_o is high, all bus accesses except a status read leave every register and the RAM unchanged.
- R10: A command byte matching none of the forms in R6 to R8, outside armed mode, changes no state and does not raise busy_o.
- R11: A pulse on ld_i loads page_o, col_o and the segment-direction flag from the side-band inputs, whether or not the block is busy. It takes priority over the column advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | One-cycle bus access strobe |
| rs_i | input | 1 | Register select: 1 data RAM, 0 command/status |
| rw_i | input | 1 | 1 read, 0 write |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte or status byte |
| rvalid_o | output | 1 | rdata_o holds a read result |
| ld_i | input | 1 | Side-band load strobe |
| ld_page_i | input | 3 | Page to load |
| ld_col_i | input | 7 | Column to load |
| ld_adc_i | input | 1 | Segment-direction flag to load |
| busy_o | output | 1 | Internal operation or init in progress |
| page_o | output | 3 | Current page |
| col_o | output | 7 | Current column |
| disp_on_o | output | 1 | Display enable |
| start_line_o | output | 6 | Start display line |
| vref_o | output | 6 | Reference voltage setting |

## Verification
On every cycle the assertions check the following: register state is frozen while busy, a write raises busy, a RAM access wraps the column, a read produces a valid result, the status low nibble reads as zero, and side-band loads take effect. Some behaviour can only be shown by the bench's scenarios. This covers stored data read back after other traffic, the two-byte voltage sequence including a foreign byte taken as the parameter, the reset window seen through status reads, and unknown commands leaving busy low. The bench checks all of these against a reference model. That model runs long random mixes of accesses under a fixed seed.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_WR, OP_RD, OP_STAT, OP_DISP, OP_LINE, OP_VARM, OP_VPRM
  } op_e;

  localparam logic [6:0] DISP_PFX = 7'b1010111;
  localparam logic [7:0] VARM_CMD = 8'h81;

  function automatic op_e cmd_class(input logic [7:0] b, input logic armed);
    if (armed)                  return OP_VPRM;
    else if (b[7:1] == DISP_PFX) return OP_DISP;
    else if (b[7:6] == 2'b01)   return OP_LINE;
    else if (b == VARM_CMD)     return OP_VARM;
    else                        return OP_NONE;
  endfunction
endpackage

// File: rtl/lcd_op_dec.sv
module lcd_op_dec
  import lcd_pkg::*;
(
  input  logic       acc_i,
  input  logic       rs_i,
  input  logic       rw_i,
  input  logic [7:0] byte_i,
  input  logic       busy_i,
  input  logic       armed_i,
  output op_e        op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (acc_i) begin
      if (!rs_i && rw_i)  op_o = OP_STAT;   // status always served
      else if (!busy_i) begin
        if (rs_i)         op_o = rw_i ? OP_RD : OP_WR;
        else              op_o = cmd_class(byte_i, armed_i);
      end
    end
  end
endmodule

// File: rtl/lcd_busy_tmr.sv
module lcd_busy_tmr #(
  parameter int RST_CYC = 4,
  parameter int OP_CYC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic init_o
);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam int OW = $clog2(OP_CYC + 1);

  logic [RW-1:0] rst_cnt_q;
  logic [OW-1:0] op_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_cnt_q <= RW'(RST_CYC);
      op_cnt_q  <= '0;
    end else begin
      if (rst_cnt_q != '0) rst_cnt_q <= rst_cnt_q - 1'b1;
      if (start_i)             op_cnt_q <= OW'(OP_CYC);
      else if (op_cnt_q != '0) op_cnt_q <= op_cnt_q - 1'b1;
    end
  end

  assign init_o = (rst_cnt_q != '0);
  assign busy_o = init_o || (op_cnt_q != '0);
endmodule

// File: rtl/lcd_dd_ram.sv
module lcd_dd_ram #(
  parameter int PAGES = 8,
  parameter int COLS  = 128,
  parameter int DW    = 8
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(PAGES)-1:0] page_i,
  input  logic [$clog2(COLS)-1:0]  col_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o
);
  localparam int DEPTH = PAGES * COLS;
  localparam int AW    = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] addr;

  assign addr = {page_i, col_i};

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr] <= wdata_i;
    rdata_o <= mem_q[addr];
  end
endmodule

// File: rtl/lcd_cmd_interp.sv
module lcd_cmd_interp
  import lcd_pkg::*;
#(
  parameter int PAGES   = 8,
  parameter int COLS    = 128,
  parameter int RST_CYC = 4,
  parameter int OP_CYC  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     acc_i,
  input  logic                     rs_i,
  input  logic                     rw_i,
  input  logic [7:0]               wdata_i,
  output logic [7:0]               rdata_o,
  output logic                     rvalid_o,
  input  logic                     ld_i,
  input  logic [$clog2(PAGES)-1:0] ld_page_i,
  input  logic [$clog2(COLS)-1:0]  ld_col_i,
  input  logic                     ld_adc_i,
  output logic                     busy_o,
  output logic [$clog2(PAGES)-1:0] page_o,
  output logic [$clog2(COLS)-1:0]  col_o,
  output logic                     disp_on_o,
  output logic [5:0]               start_line_o,
  output logic [5:0]               vref_o
);
  localparam int PW = $clog2(PAGES);
  localparam int CW = $clog2(COLS);

  op_e           op;
  logic          init;
  logic          armed_q, adc_q, stat_sel_q, rvalid_q;
  logic [7:0]    stat_q, ram_q;
  logic [PW-1:0] page_q;
  logic [CW-1:0] col_q;
  logic          accepted, ram_acc;

  lcd_op_dec u_dec (
    .acc_i  (acc_i),
    .rs_i   (rs_i),
    .rw_i   (rw_i),
    .byte_i (wdata_i),
    .busy_i (busy_o),
    .armed_i(armed_q),
    .op_o   (op)
  );

  assign accepted = (op == OP_WR) || (op == OP_DISP) || (op == OP_LINE) ||
                    (op == OP_VARM) || (op == OP_VPRM);
  assign ram_acc  = (op == OP_WR) || (op == OP_RD);

  lcd_busy_tmr #(.RST_CYC(RST_CYC), .OP_CYC(OP_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accepted),
    .busy_o (busy_o),
    .init_o (init)
  );

  lcd_dd_ram #(.PAGES(PAGES), .COLS(COLS), .DW(8)) u_ram (
    .clk_i  (clk_i),
    .we_i   (op == OP_WR),
    .page_i (page_q),
    .col_i  (col_q),
    .wdata_i(wdata_i),
    .rdata_o(ram_q)
  );

  // address pointer: side-band load wins over auto advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      col_q  <= '0;
      adc_q  <= 1'b0;
    end else if (ld_i) begin
      page_q <= ld_page_i;
      col_q  <= ld_col_i;
      adc_q  <= ld_adc_i;
    end else if (ram_acc) begin
      col_q  <= (col_q == CW'(COLS - 1)) ? '0 : col_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_on_o    <= 1'b0;
      start_line_o <= '0;
      vref_o       <= '0;
      armed_q      <= 1'b0;
    end else begin
      unique case (op)
        OP_DISP: disp_on_o    <= wdata_i[0];
        OP_LINE: start_line_o <= wdata_i[5:0];
        OP_VARM: armed_q      <= 1'b1;
        OP_VPRM: begin
          vref_o  <= wdata_i[5:0];
          armed_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q     <= '0;
      stat_sel_q <= 1'b0;
      rvalid_q   <= 1'b0;
    end else begin
      rvalid_q   <= (op == OP_RD) || (op == OP_STAT);
      stat_sel_q <= (op == OP_STAT);
      if (op == OP_STAT) stat_q <= {busy_o, adc_q, disp_on_o, init, 4'b0000};
    end
  end

  assign rdata_o  = stat_sel_q ? stat_q : ram_q;
  assign rvalid_o = rvalid_q;
  assign page_o   = page_q;
  assign col_o    = col_q;
endmodule

// File: rtl/lcd_cmd_interp_chk.sv
module lcd_cmd_interp_chk #(
  parameter int PAGES = 8,
  parameter int COLS  = 128
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     acc_i,
  input logic                     rs_i,
  input logic                     rw_i,
  input logic                     ld_i,
  input logic [$clog2(PAGES)-1:0] ld_page_i,
  input logic [$clog2(COLS)-1:0]  ld_col_i,
  input logic                     busy_o,
  input logic [$clog2(PAGES)-1:0] page_o,
  input logic [$clog2(COLS)-1:0]  col_o,
  input logic                     disp_on_o,
  input logic [5:0]               start_line_o,
  input logic [5:0]               vref_o,
  input logic [7:0]               rdata_o,
  input logic                     rvalid_o
);
  // R9
  busy_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ld_i) |=> ($stable(col_o) && $stable(page_o) && $stable(disp_on_o)
                           && $stable(start_line_o) && $stable(vref_o)));

  // R2
  wr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && rs_i && !rw_i && !busy_o) |=> busy_o);

  // R4
  col_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && rs_i && !busy_o && !ld_i && col_o == $clog2(COLS)'(COLS - 1))
      |=> (col_o == '0 && $stable(page_o)));

  // R3
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && rs_i && rw_i && !busy_o) |=> rvalid_o);

  // R5
  stat_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !rs_i && rw_i) |=> (rvalid_o && rdata_o[3:0] == 4'h0));

  // R11
  sideband_ld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (page_o == $past(ld_page_i) && col_o == $past(ld_col_i)));
endmodule

bind lcd_cmd_interp lcd_cmd_interp_chk #(.PAGES(PAGES), .COLS(COLS)) u_chk (.*);

// File: tb/lcd_cmd_interp_bench.sv
module lcd_cmd_interp_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       acc_i = 1'b0, rs_i = 1'b0, rw_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rvalid_o;
  logic       ld_i = 1'b0, ld_adc_i = 1'b0;
  logic [2:0] ld_page_i = '0, page_o;
  logic [6:0] ld_col_i = '0, col_o;
  logic       busy_o, disp_on_o;
  logic [5:0] start_line_o, vref_o;

  int errors = 0, checks = 0;

  // reference model
  logic [7:0] m_mem [1024];
  bit         m_vld [1024];
  logic [2:0] m_page = '0;
  logic [6:0] m_col = '0;
  logic       m_on = 1'b0, m_adc = 1'b0, m_armed = 1'b0;
  logic [5:0] m_line = '0, m_vref = '0;

  always #2 clk_i = ~clk_i;

  lcd_cmd_interp u_lcd_cmd_interp (.*);

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_byte(input logic b, input logic i);
    return {b, m_adc, m_on, i, 4'b0000};
  endfunction

  task automatic chk_regs(input string req);
    chk(page_o == m_page, req, page_o, m_page);
    chk(col_o == m_col, req, col_o, m_col);
    chk(disp_on_o == m_on, req, disp_on_o, m_on);
    chk(start_line_o == m_line, req, start_line_o, m_line);
    chk(vref_o == m_vref, req, vref_o, m_vref);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
  endtask

  // one access, block assumed idle; updates model and checks result
  task automatic access(input logic rs, input logic rw, input logic [7:0] d, input string req);
    int a;
    @(negedge clk_i);
    acc_i = 1'b1; rs_i = rs; rw_i = rw; wdata_i = d;
    @(negedge clk_i);
    acc_i = 1'b0;
    a = {m_page, m_col};
    if (rs) begin
      if (rw) begin
        chk(rvalid_o, req, rvalid_o, 1);
        if (m_vld[a]) chk(rdata_o == m_mem[a], req, rdata_o, m_mem[a]);
      end else begin
        m_mem[a] = d; m_vld[a] = 1'b1;
        chk(busy_o, req, busy_o, 1);
      end
      m_col = m_col + 1'b1;
    end else if (rw) begin
      chk(rdata_o == stat_byte(1'b0, 1'b0), req, rdata_o, stat_byte(1'b0, 1'b0));
    end else begin
      if (m_armed) begin m_vref = d[5:0]; m_armed = 1'b0; end
      else if (d[7:1] == 7'b1010111) m_on = d[0];
      else if (d[7:6] == 2'b01) m_line = d[5:0];
      else if (d == 8'h81) m_armed = 1'b1;
      else chk(!busy_o, req, busy_o, 0);   // unknown command: no busy
    end
    chk_regs(req);
    wait_idle();
  endtask

  task automatic sideband(input logic [2:0] p, input logic [6:0] c, input logic adc);
    @(negedge clk_i);
    ld_i = 1'b1; ld_page_i = p; ld_col_i = c; ld_adc_i = adc;
    @(negedge clk_i);
    ld_i = 1'b0;
    m_page = p; m_col = c; m_adc = adc;
    chk_regs("R11");
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1cd5eed);
    repeat (3) @(negedge clk_i);
    // R1: reset values
    chk_regs("R1");
    chk(busy_o, "R1", busy_o, 1);
    rst_ni = 1'b1;
    // status read at first edge after release: busy and init set
    acc_i = 1'b1; rs_i = 1'b0; rw_i = 1'b1;
    @(negedge clk_i);
    acc_i = 1'b0;
    chk(rdata_o == 8'h90, "R1", rdata_o, 8'h90);
    chk(busy_o, "R1", busy_o, 1);
    repeat (2) @(negedge clk_i);
    chk(busy_o, "R1", busy_o, 1);
    @(negedge clk_i);
    chk(!busy_o, "R1", busy_o, 0);

    access(1'b0, 1'b0, 8'hAF, "R6");
    access(1'b0, 1'b1, 8'h00, "R5");
    access(1'b0, 1'b0, 8'h7F, "R7");
    access(1'b0, 1'b0, 8'h81, "R8");
    access(1'b0, 1'b0, 8'hE5, "R8");
    chk(vref_o == 6'h25, "R8", vref_o, 6'h25);
    access(1'b0, 1'b0, 8'h81, "R8");
    access(1'b0, 1'b0, 8'hAE, "R8");      // foreign byte taken as parameter
    chk(vref_o == 6'h2E && disp_on_o == 1'b1, "R8", {disp_on_o, vref_o}, 7'h6E);
    access(1'b0, 1'b0, 8'h00, "R10");
    access(1'b0, 1'b0, 8'hC3, "R10");

    // R4 wrap
    sideband(3'd3, 7'd126, 1'b0);
    access(1'b1, 1'b0, 8'hA1, "R2");
    access(1'b1, 1'b0, 8'hA2, "R4");
    access(1'b1, 1'b0, 8'hA3, "R4");
    chk(col_o == 7'd1 && page_o == 3'd3, "R4", {page_o, col_o}, {3'd3, 7'd1});
    sideband(3'd3, 7'd126, 1'b1);
    access(1'b1, 1'b1, 8'h00, "R3");
    access(1'b1, 1'b1, 8'h00, "R4");
    access(1'b1, 1'b1, 8'h00, "R3");
    access(1'b0, 1'b1, 8'h00, "R5");

    // R9: access while busy
    @(negedge clk_i);
    acc_i = 1'b1; rs_i = 1'b0; rw_i = 1'b0; wdata_i = 8'h45;
    @(negedge clk_i);
    m_line = 6'h05;
    wdata_i = 8'hAE;                          // busy: ignored
    @(negedge clk_i);
    rw_i = 1'b1;                              // status while busy
    @(negedge clk_i);
    acc_i = 1'b0;
    chk(rdata_o == stat_byte(1'b1, 1'b0), "R9", rdata_o, stat_byte(1'b1, 1'b0));
    chk_regs("R9");
    @(negedge clk_i);
    acc_i = 1'b1; rs_i = 1'b1; rw_i = 1'b0; wdata_i = 8'h11;
    @(negedge clk_i);
    wdata_i = 8'h22;                          // busy: ignored, no advance
    @(negedge clk_i);
    acc_i = 1'b0;
    m_mem[{m_page, m_col}] = 8'h11; m_vld[{m_page, m_col}] = 1'b1;
    m_col = m_col + 1'b1;
    chk_regs("R9");
    wait_idle();

    // random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 3)       access(1'b1, 1'b0, 8'($urandom), "R2");
      else if (k < 5)  access(1'b1, 1'b1, 8'h00, "R3");
      else if (k == 5) access(1'b0, 1'b1, 8'h00, "R5");
      else if (k == 6) access(1'b0, 1'b0, {7'b1010111, 1'($urandom)}, "R6");
      else if (k == 7) access(1'b0, 1'b0, 8'($urandom), "R10");
      else if (k == 8) access(1'b0, 1'b0, 8'h81, "R8");
      else sideband(3'($urandom), 7'($urandom_range(120, 127)), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule